// File: doc/BRIEF.md
# Network Controller Host Data Port with Remote DMA Pointer

This block is the host-facing side of a simple Ethernet controller's remote DMA path. Software loads a starting byte address and a byte count through small byte-wide registers, then moves packet data through a single data port. Each data-port access transfers one byte or one 16-bit little-endian word to or from the controller's on-board packet memory, and the address and the remaining count move on by the access width. The block also holds the shared interrupt status byte, the interrupt mask and the interrupt line, because the remote DMA path owns the reset-indication bit and the transfer-complete bit.

Packet memory is sparse. Only a 32-byte low window and a 32 KiB buffer that begins at byte 16384 exist. The block drives a 16-bit-wide synchronous memory port with byte enables, and it only issues a memory access when the address falls inside one of the two windows. Reads outside them return all-ones, and writes outside them are dropped. The other sections of the controller raise the low six status bits through an event input.

Top module: `nic_rdma_port`

## Requirements
- R1: After reset the address and count are zero, the status byte reads 0x80, the mask reads 0x00, byte mode is selected and `irq` is low.
- R2: The register offsets on `host_addr` are 0 command, 1 address bits 7:0, 2 address bits 15:8, 3 count bits 7:0, 4 count bits 15:8, 5 status, 6 mask, 7 configuration, 8 data port. The address reads back at offsets 1 and 2. The count offsets and every offset other than 1, 2, 5, 6, 7 and 8 read as 0.
- R3: Valid memory is bytes 0 to 31 and 16384 to 49151. A byte read outside them returns 0x00FF and a word read returns 0xFFFF. A write outside them raises no `mem_wr`.
- R4: Bit 0 of the configuration register selects word mode (1) or byte mode (0). In word mode the effective address has bit 0 cleared and the word is little-endian: `host_wdata[7:0]` is stored at the even byte and `host_wdata[15:8]` at the odd one. A byte access uses lane 0 (`mem_be`=01) at an even address and lane 1 (`mem_be`=10) at an odd one.
- R5: Every data read and every data write that is not ignored advances the address by 2 in word mode or by 1 in byte mode. It lowers the count by the same amount, saturating at 0. A data read proceeds even when the count is zero.
- R6: A data-port write while the count is zero raises no `mem_wr` and leaves the address and the count unchanged.
- R7: Status bit 6 is set when a data access takes the count from nonzero to zero.
- R8: A status write clears the status bits that are 1 in bits 6:0 of the written byte. Bit 7 is never cleared this way.
- R9: A command write with bit 0 set clears status bit 7. If bit 1 (remote read) or bit 2 (remote write) is also set while the count is zero, status bit 6 is set.
- R10: Each `ev_in` bit sets the matching status bit in 5:0. `irq` is high exactly when some status bit and its mask bit are both 1.
- R11: A read presented on `host_rd` (with `host_wr` low) returns `host_rvalid` high and its data on `host_rdata` in the next cycle. Register and byte reads are zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 16 | Write data; registers use bits 7:0 |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| ev_in | input | 6 | Status event pulses from other controller sections |
| irq | output | 1 | Interrupt request |
| mem_addr | output | 15 | Packet memory word address |
| mem_wr | output | 1 | Packet memory write |
| mem_rd | output | 1 | Packet memory read; data returns next cycle |
| mem_be | output | 2 | Byte-lane enables for a write |
| mem_wdata | output | 16 | Packet memory write data |
| mem_rdata | input | 16 | Packet memory read data |

## Verification
The data port is driven with random starting addresses clustered at the low window edge, at both ends of the buffer and anywhere in the space, with random small counts and random width switches between accesses. This separates a correct window decode from an off-by-one at 31/32, 16383/16384 and 49151/49152, and word steps from byte steps. Directed sequences write a word at an odd address and read it back as bytes, which shows the even-forcing and the lane order. Writes issued with a count of zero, counts of one in word mode, and status writes of 0xFF tell saturation, the ignore rule, the completion bit and the protected reset bit apart from their look-alikes.

// File: rtl/nic_rdma_pkg.sv
package nic_rdma_pkg;
  localparam int HA_W   = 4;
  localparam int STAT_W = 8;
  localparam int EV_W   = STAT_W - 2;

  localparam logic [HA_W-1:0] OFS_CMD     = 4'd0;
  localparam logic [HA_W-1:0] OFS_ADDR_LO = 4'd1;
  localparam logic [HA_W-1:0] OFS_ADDR_HI = 4'd2;
  localparam logic [HA_W-1:0] OFS_CNT_LO  = 4'd3;
  localparam logic [HA_W-1:0] OFS_CNT_HI  = 4'd4;
  localparam logic [HA_W-1:0] OFS_STAT    = 4'd5;
  localparam logic [HA_W-1:0] OFS_MASK    = 4'd6;
  localparam logic [HA_W-1:0] OFS_CFG     = 4'd7;
  localparam logic [HA_W-1:0] OFS_DATA    = 4'd8;

  localparam int CMD_GO  = 0;
  localparam int CMD_RRD = 1;
  localparam int CMD_RWR = 2;

  typedef enum logic [2:0] {
    RS_REG, RS_BLO, RS_BHI, RS_WORD, RS_ONE_B, RS_ONE_W
  } rsel_e;
endpackage

// File: rtl/rdma_window.sv
module rdma_window #(
  parameter int AW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int BUF_BASE  = 16384,
  parameter int BUF_BYTES = 32768
) (
  input  logic [AW-1:0] addr,
  input  logic          word,
  output logic [AW-1:0] eff,
  output logic          hit
);
  localparam int unsigned LO_END = LOW_BYTES;
  localparam int unsigned B_LO   = BUF_BASE;
  localparam int unsigned B_END  = BUF_BASE + BUF_BYTES;

  int unsigned ea;

  assign eff = word ? {addr[AW-1:1], 1'b0} : addr;
  assign ea  = 32'(eff);
  assign hit = (ea < LO_END) || ((ea >= B_LO) && (ea < B_END));
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr_lo,
  input  logic          ld_addr_hi,
  input  logic          ld_cnt_lo,
  input  logic          ld_cnt_hi,
  input  logic [7:0]    wbyte,
  input  logic          step,
  input  logic          word,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          cnt_nz,
  output logic          done_set
);
  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [AW-1:0] A_TWO = AW'(2);
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [CW-1:0] C_TWO = CW'(2);

  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] dec;
  logic          addr_en;
  logic          cnt_en;

  assign cnt_nz  = |cnt_q;
  assign dec     = word ? C_TWO : C_ONE;
  assign addr_en = ld_addr_lo | ld_addr_hi | step;
  assign cnt_en  = ld_cnt_lo | ld_cnt_hi | step;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (ld_addr_lo) addr_d[7:0]    = wbyte;
    if (ld_addr_hi) addr_d[AW-1:8] = wbyte[AW-9:0];
    if (ld_cnt_lo)  cnt_d[7:0]     = wbyte;
    if (ld_cnt_hi)  cnt_d[CW-1:8]  = wbyte[CW-9:0];
    if (step) begin
      addr_d = addr_q + (word ? A_TWO : A_ONE);
      cnt_d  = (cnt_q > dec) ? (cnt_q - dec) : '0;
    end
  end

  assign done_set = step && cnt_nz && (cnt_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/rdma_status.sv
module rdma_status #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_wr,
  input  logic          mask_wr,
  input  logic [SW-1:0] wbyte,
  input  logic          go,
  input  logic          req_zero,
  input  logic          done_set,
  input  logic [SW-3:0] ev_in,
  output logic [SW-1:0] stat_q,
  output logic [SW-1:0] mask_q,
  output logic          irq
);
  localparam int RST_BIT  = SW - 1;
  localparam int DONE_BIT = SW - 2;
  localparam logic [SW-1:0] STAT_INIT = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] stat_d;
  logic          stat_en;

  assign stat_en = stat_wr | go | (|ev_in) | done_set | req_zero;

  always_comb begin
    stat_d = stat_q;
    if (stat_wr) stat_d = stat_q & ~{1'b0, wbyte[SW-2:0]};
    if (go) stat_d[RST_BIT] = 1'b0;
    stat_d[SW-3:0] = stat_d[SW-3:0] | ev_in;
    if (done_set || req_zero) stat_d[DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_INIT;
      mask_q <= '0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (mask_wr) mask_q <= wbyte;
    end
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/nic_rdma_port.sv
module nic_rdma_port
  import nic_rdma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int BUF_BASE  = 16384,
  parameter int BUF_BYTES = 32768
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HA_W-1:0] host_addr,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  output logic            host_rvalid,
  input  logic [EV_W-1:0] ev_in,
  output logic            irq,
  output logic [AW-2:0]   mem_addr,
  output logic            mem_wr,
  output logic            mem_rd,
  output logic [1:0]      mem_be,
  output logic [15:0]     mem_wdata,
  input  logic [15:0]     mem_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_core_n <= rst_s1;
    end
  end

  // host decode
  logic rd_en, data_wr, data_rd, go, req_zero;
  logic [7:0] wbyte;
  assign rd_en   = host_rd && !host_wr;
  assign data_wr = host_wr && (host_addr == OFS_DATA);
  assign data_rd = rd_en && (host_addr == OFS_DATA);
  assign wbyte   = host_wdata[7:0];

  // configuration: access width
  logic cfg_word;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)                           cfg_word <= 1'b0;
    else if (host_wr && host_addr == OFS_CFG)  cfg_word <= wbyte[0];
  end

  // pointer and count
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_nz, done_set, step;

  assign step = (data_wr && cnt_nz) || data_rd;

  rdma_ptr #(.AW(AW), .CW(CW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ld_addr_lo (host_wr && host_addr == OFS_ADDR_LO),
    .ld_addr_hi (host_wr && host_addr == OFS_ADDR_HI),
    .ld_cnt_lo  (host_wr && host_addr == OFS_CNT_LO),
    .ld_cnt_hi  (host_wr && host_addr == OFS_CNT_HI),
    .wbyte      (wbyte),
    .step       (step),
    .word       (cfg_word),
    .addr_q     (addr_q),
    .cnt_q      (cnt_q),
    .cnt_nz     (cnt_nz),
    .done_set   (done_set)
  );

  // window decode
  logic [AW-1:0] eff;
  logic          win_hit;

  rdma_window #(
    .AW(AW), .LOW_BYTES(LOW_BYTES), .BUF_BASE(BUF_BASE), .BUF_BYTES(BUF_BYTES)
  ) u_win (
    .addr (addr_q),
    .word (cfg_word),
    .eff  (eff),
    .hit  (win_hit)
  );

  // status, mask, interrupt
  logic [STAT_W-1:0] stat_q, mask_q;

  assign go       = host_wr && (host_addr == OFS_CMD) && host_wdata[CMD_GO];
  assign req_zero = go && (host_wdata[CMD_RRD] || host_wdata[CMD_RWR]) && !cnt_nz;

  rdma_status #(.SW(STAT_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .stat_wr  (host_wr && host_addr == OFS_STAT),
    .mask_wr  (host_wr && host_addr == OFS_MASK),
    .wbyte    (wbyte),
    .go       (go),
    .req_zero (req_zero),
    .done_set (done_set),
    .ev_in    (ev_in),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  // memory port
  assign mem_addr = eff[AW-1:1];
  assign mem_wr   = data_wr && cnt_nz && win_hit;
  assign mem_rd   = data_rd && win_hit;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign mem_wdata[l*8 +: 8] = cfg_word ? host_wdata[l*8 +: 8] : wbyte;
    assign mem_be[l]           = cfg_word || (eff[0] == 1'(l));
  end

  // read return path
  rsel_e      rsel_d, rsel_q;
  logic [7:0] rreg_d, rreg_q;

  always_comb begin
    rsel_d = RS_REG;
    rreg_d = 8'h00;
    if (data_rd) begin
      if (!win_hit)     rsel_d = cfg_word ? RS_ONE_W : RS_ONE_B;
      else if (cfg_word) rsel_d = RS_WORD;
      else if (eff[0])   rsel_d = RS_BHI;
      else               rsel_d = RS_BLO;
    end else begin
      case (host_addr)
        OFS_ADDR_LO: rreg_d = addr_q[7:0];
        OFS_ADDR_HI: rreg_d = 8'(addr_q >> 8);
        OFS_STAT:    rreg_d = stat_q;
        OFS_MASK:    rreg_d = mask_q;
        OFS_CFG:     rreg_d = {7'b0, cfg_word};
        default:     rreg_d = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      host_rvalid <= 1'b0;
      rsel_q      <= RS_REG;
      rreg_q      <= 8'h00;
    end else begin
      host_rvalid <= rd_en;
      if (rd_en) begin
        rsel_q <= rsel_d;
        rreg_q <= rreg_d;
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RS_BLO:   host_rdata = {8'h00, mem_rdata[7:0]};
      RS_BHI:   host_rdata = {8'h00, mem_rdata[15:8]};
      RS_WORD:  host_rdata = mem_rdata;
      RS_ONE_B: host_rdata = 16'h00FF;
      RS_ONE_W: host_rdata = 16'hFFFF;
      default:  host_rdata = {8'h00, rreg_q};
    endcase
  end
endmodule

// File: rtl/rdma_chk.sv
module rdma_chk
  import nic_rdma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int BUF_BASE  = 16384,
  parameter int BUF_BYTES = 32768
) (
  input logic            clk,
  input logic            rst_n,
  input logic [HA_W-1:0] host_addr,
  input logic            host_wr,
  input logic            host_rd,
  input logic            go_bit,
  input logic            host_rvalid,
  input logic            mem_wr,
  input logic            mem_rd,
  input logic [AW-2:0]   mem_addr,
  input logic [AW-1:0]   addr_q,
  input logic [CW-1:0]   cnt_q,
  input logic            rst_bit,
  input logic            word
);
  localparam int unsigned B_END = BUF_BASE + BUF_BYTES;

  int unsigned ma;
  logic        ma_ok;
  assign ma    = 32'({mem_addr, 1'b0});
  assign ma_ok = (ma < 32'(LOW_BYTES)) || ((ma >= 32'(BUF_BASE)) && (ma < B_END));

  // R3
  win_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> ma_ok);

  // R6
  zero_cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_DATA && cnt_q == '0) |-> !mem_wr);

  // R8
  rst_bit_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_bit) |-> $past(host_wr && host_addr == OFS_CMD && go_bit));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_DATA && cnt_q != '0) |=>
      (addr_q == $past(addr_q) + ($past(word) ? AW'(2) : AW'(1))));

  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> host_rvalid);

  // R5
  cnt_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > $past(cnt_q)) |->
      $past(host_wr && (host_addr == OFS_CNT_LO || host_addr == OFS_CNT_HI)));
endmodule

bind nic_rdma_port rdma_chk #(
  .AW(AW), .CW(CW), .LOW_BYTES(LOW_BYTES), .BUF_BASE(BUF_BASE), .BUF_BYTES(BUF_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .host_addr   (host_addr),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .go_bit      (host_wdata[0]),
  .host_rvalid (host_rvalid),
  .mem_wr      (mem_wr),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .addr_q      (addr_q),
  .cnt_q       (cnt_q),
  .rst_bit     (stat_q[7]),
  .word        (cfg_word)
);

// File: tb/tb_nic_rdma_port.sv
`timescale 1ns/1ps
module tb_nic_rdma_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  host_addr;
  logic        host_wr, host_rd;
  logic [15:0] host_wdata, host_rdata;
  logic        host_rvalid;
  logic [5:0]  ev_in;
  logic        irq;
  logic [14:0] mem_addr;
  logic        mem_wr, mem_rd;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  nic_rdma_port dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .ev_in(ev_in), .irq(irq), .mem_addr(mem_addr),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // packet memory seen by the design
  logic [7:0] bmem [int];
  function automatic logic [7:0] bget(int a);
    return bmem.exists(a) ? bmem[a] : 8'h00;
  endfunction
  always @(posedge clk) begin
    if (mem_wr) begin
      if (mem_be[0]) bmem[int'({mem_addr, 1'b0})] = mem_wdata[7:0];
      if (mem_be[1]) bmem[int'({mem_addr, 1'b1})] = mem_wdata[15:8];
    end
    if (mem_rd) mem_rdata <= {bget(int'({mem_addr, 1'b1})), bget(int'({mem_addr, 1'b0}))};
  end

  // reference model
  logic [7:0]  emem [int];
  logic [15:0] m_addr, m_cnt;
  logic [7:0]  m_stat, m_mask;
  logic        m_word;
  int n_chk = 0, n_fail = 0;
  logic seen_we, finished = 1'b0;

  function automatic logic [7:0] eget(int a);
    return emem.exists(a) ? emem[a] : 8'h00;
  endfunction
  function automatic logic win(logic [15:0] a);
    return (a < 16'd32) || (a >= 16'd16384 && a < 16'd49152);
  endfunction
  function automatic logic [15:0] eff_of(logic [15:0] a, logic w);
    return w ? {a[15:1], 1'b0} : a;
  endfunction
  function automatic logic [15:0] exp_reg(logic [3:0] a);
    case (a)
      4'd1: return {8'h00, m_addr[7:0]};
      4'd2: return {8'h00, m_addr[15:8]};
      4'd5: return {8'h00, m_stat};
      4'd6: return {8'h00, m_mask};
      4'd7: return {15'd0, m_word};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_step();
    logic [15:0] dec = m_word ? 16'd2 : 16'd1;
    logic [15:0] old = m_cnt;
    m_addr = m_addr + dec;
    m_cnt  = (m_cnt > dec) ? m_cnt - dec : 16'd0;
    if (old != 0 && m_cnt == 0) m_stat[6] = 1'b1;
  endtask

  task automatic cyc_wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    #1 seen_we = mem_wr;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic cyc_rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    check("R11 rvalid", {15'd0, host_rvalid}, 16'd1);
    d = host_rdata;
  endtask

  task automatic m_wr(logic [3:0] a, logic [15:0] d);
    logic [15:0] ea = eff_of(m_addr, m_word);
    logic exp_we = (a == 4'd8) && (m_cnt != 0) && win(ea);
    cyc_wr(a, d);
    case (a)
      4'd0: if (d[0]) begin
              m_stat[7] = 1'b0;
              if ((d[1] || d[2]) && m_cnt == 0) m_stat[6] = 1'b1;
            end
      4'd1: m_addr[7:0]  = d[7:0];
      4'd2: m_addr[15:8] = d[7:0];
      4'd3: m_cnt[7:0]   = d[7:0];
      4'd4: m_cnt[15:8]  = d[7:0];
      4'd5: m_stat = m_stat & ~(d[7:0] & 8'h7F);
      4'd6: m_mask = d[7:0];
      4'd7: m_word = d[0];
      4'd8: begin
        check(m_cnt == 0 ? "R6 mem_wr at zero count" : "R3 mem_wr window",
              {15'd0, seen_we}, {15'd0, exp_we});
        if (m_cnt != 0) begin
          if (win(ea)) begin
            if (m_word) begin emem[int'(ea)] = d[7:0]; emem[int'(ea) + 1] = d[15:8]; end
            else emem[int'(ea)] = d[7:0];
          end
          m_step();
        end
      end
      default: ;
    endcase
    check("R10 irq", {15'd0, irq}, {15'd0, |(m_stat & m_mask)});
  endtask

  task automatic m_rd(logic [3:0] a, string tag, output logic [15:0] got);
    logic [15:0] exp;
    logic [15:0] ea = eff_of(m_addr, m_word);
    if (a == 4'd8) begin
      if (!win(ea)) exp = m_word ? 16'hFFFF : 16'h00FF;
      else if (m_word) exp = {eget(int'(ea) + 1), eget(int'(ea))};
      else exp = {8'h00, eget(int'(ea))};
    end else exp = exp_reg(a);
    cyc_rd(a, got);
    check(tag, got, exp);
    if (a == 4'd8) m_step();
  endtask

  task automatic set_addr(logic [15:0] v);
    m_wr(4'd1, {8'h00, v[7:0]});
    m_wr(4'd2, {8'h00, v[15:8]});
  endtask
  task automatic set_cnt(logic [15:0] v);
    m_wr(4'd3, {8'h00, v[7:0]});
    m_wr(4'd4, {8'h00, v[15:8]});
  endtask

  task automatic pulse_ev(logic [5:0] v);
    @(negedge clk); ev_in = v;
    @(negedge clk); ev_in = 6'd0;
    m_stat[5:0] = m_stat[5:0] | v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    rst_n = 1'b0; host_addr = 4'd0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = 16'd0; ev_in = 6'd0;
    m_addr = 0; m_cnt = 0; m_stat = 8'h80; m_mask = 0; m_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    m_rd(4'd1, "R1 addr lo", g); m_rd(4'd2, "R1 addr hi", g);
    m_rd(4'd5, "R1 status", g); check("R1 status 0x80", g, 16'h0080);
    m_rd(4'd6, "R1 mask", g); m_rd(4'd7, "R1 cfg", g);
    // R6 zero-count write ignored, address kept
    m_wr(4'd8, 16'h1234);
    m_rd(4'd1, "R6 addr unchanged", g); check("R6 addr lo zero", g, 16'h0000);
    // R5 read proceeds at zero count
    m_rd(4'd8, "R5 read at zero count", g);
    m_rd(4'd1, "R5 addr step", g); check("R5 addr now 1", g, 16'h0001);
    // R2 count offsets read zero
    set_cnt(16'h0305);
    m_rd(4'd3, "R2 cnt lo reads 0", g); m_rd(4'd4, "R2 cnt hi reads 0", g);
    m_rd(4'd9, "R2 unused offset", g);
    set_cnt(16'h0000);
    // R8 protected reset bit
    m_wr(4'd5, 16'h00FF);
    m_rd(4'd5, "R8 status after 0xFF", g); check("R8 bit7 kept", g, 16'h0080);
    // R9 start clears bit 7; start with request at zero count sets bit 6
    m_wr(4'd0, 16'h0001);
    m_rd(4'd5, "R9 go clears bit7", g); check("R9 status 0", g, 16'h0000);
    m_wr(4'd0, 16'h0003);
    m_rd(4'd5, "R9 zero-count request", g); check("R9 bit6", g, 16'h0040);
    m_wr(4'd5, 16'h0040);
    // R4 word at odd address, read back as bytes
    m_wr(4'd7, 16'h0001);
    set_addr(16'h4001); set_cnt(16'd4);
    m_wr(4'd8, 16'hBEEF);
    m_wr(4'd7, 16'h0000);
    set_addr(16'h4000);
    m_rd(4'd8, "R4 low byte", g); check("R4 even byte EF", g, 16'h00EF);
    m_rd(4'd8, "R4 high byte", g); check("R4 odd byte BE", g, 16'h00BE);
    // R3 window edges
    set_addr(16'd16383); m_rd(4'd8, "R3 below buffer", g); check("R3 ones byte", g, 16'h00FF);
    set_addr(16'd49151); m_rd(4'd8, "R3 last byte", g);
    m_rd(4'd8, "R3 past end", g); check("R3 ones at 49152", g, 16'h00FF);
    m_wr(4'd7, 16'h0001);
    set_addr(16'd32); m_rd(4'd8, "R3 word out", g); check("R3 ones word", g, 16'hFFFF);
    set_addr(16'd31); set_cnt(16'd2); m_wr(4'd8, 16'hA55A);
    set_addr(16'd30); m_rd(4'd8, "R4 word low window", g); check("R4 word at 30", g, 16'hA55A);
    // R7 count of one in word mode saturates and completes
    m_wr(4'd5, 16'h007F);
    set_addr(16'h5000); set_cnt(16'd1);
    m_wr(4'd8, 16'h1111);
    m_rd(4'd5, "R7 done bit", g); check("R7 status 0x40", g, 16'h0040);
    m_wr(4'd8, 16'h2222);
    m_rd(4'd1, "R6 ignored after saturation", g);
    // R10 events and mask
    m_wr(4'd5, 16'h007F);
    pulse_ev(6'b100101);
    m_rd(4'd5, "R10 events latched", g);
    m_wr(4'd6, 16'h0004);
    check("R10 irq raised", {15'd0, irq}, 16'd1);
    m_wr(4'd5, 16'h0004);
    check("R10 irq cleared", {15'd0, irq}, 16'd0);
    m_wr(4'd6, 16'h0000);

    // random phase
    void'($urandom(32'd7781));
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 11);
      case (op)
        0: begin
          logic [15:0] a;
          case ($urandom_range(0, 3))
            0: a = 16'($urandom_range(0, 40));
            1: a = 16'($urandom_range(16370, 16400));
            2: a = 16'($urandom_range(49140, 49160));
            default: a = 16'($urandom);
          endcase
          set_addr(a);
          m_rd(4'd2, "R2 addr hi readback", g);
        end
        1: set_cnt(16'($urandom_range(0, 8)));
        2: m_wr(4'd7, 16'($urandom_range(0, 1)));
        3, 4, 5: m_wr(4'd8, 16'($urandom));
        6, 7, 8: m_rd(4'd8, "R3/R4/R5 data read", g);
        9: m_rd(4'd5, "R7/R9 status", g);
        10: m_wr(4'd5, 16'($urandom_range(0, 255)));
        default: if ($urandom_range(0, 1) == 0) m_wr(4'd0, 16'($urandom_range(0, 7)));
                 else m_wr(4'd6, 16'($urandom_range(0, 255)));
      endcase
    end
    m_rd(4'd1, "R2 final addr lo", g);
    m_rd(4'd5, "R8 final status", g);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule